// File: doc/BRIEF.md
# Smart card session sequencer

This controller brings up, runs and shuts down a contact smart card session for a host microcontroller. The host pulls an active-low session request to start a session. The block then turns on the card supply, the I/O buffer, the card clock and finally releases the card reset, with a programmable number of clock cycles between steps. Once the session is up, the host may ask for a programming supply by pulling one of three active-low level-select lines low. The block answers with a programming-supply enable and a two-bit level code. The analog stages downstream turn these into the real voltages.

When the host withdraws the request, or when any monitor flags a fault, the block walks the same steps back down in reverse. A fault also latches an active-low interrupt. That interrupt is released only once the card is fully powered down and the host has withdrawn its request. A new session cannot start while the interrupt is latched.

Top module: `sc_session_seq`

## Requirements
- R1: After reset every enable is low, the level code is 0 and `irq_n` is high.
- R2: The block leaves idle on the first clock edge that sees `sess_req_n` low with no fault flag set and no interrupt latched. `vcc_en` rises at that edge. `io_en`, `clk_en` and `card_rst` then each follow after STEP_CYC further edges, in that order.
- R3: With the request held low and no fault, all four session outputs stay high once activation is complete.
- R4: With the session up and no programming request active, exactly one low line on `psel_n` raises `vpp_en` at the next edge. The level code is 1 for bit 0 (12.5 V), 2 for bit 1 (15 V) and 3 for bit 2 (21 V).
- R5: If none or more than one of the `psel_n` lines is low, the programming supply stays off.
- R6: Once the programming supply is on, changes on `psel_n` are ignored until all three lines are high. The edge that sees all three high turns `vpp_en` off and the level code back to 0.
- R7: On a request withdrawal the block drives `card_rst` and `clk_en` low at the next edge. STEP_CYC edges later it drops `io_en` and `vpp_en`. STEP_CYC edges after that it drops `vcc_en`.
- R8: The block re-enters idle on the edge after `vcc_en` falls, and it can accept a new request on the edge after that.
- R9: Any one of the six `flt` bits seen high at an edge drives `irq_n` low after that edge. If a session is active, that same edge also performs the first shutdown step.
- R10: A fault during activation starts the shutdown from the step reached so far and skips the steps that were never reached.
- R11: `irq_n` returns high one edge after the block is idle with `sess_req_n` high and no fault flag set, and never earlier.
- R12: While `irq_n` is low, or while a fault flag is high, a low `sess_req_n` does not start a session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_req_n | input | 1 | Session request from host, low = session wanted |
| psel_n | input | 3 | Programming level select, active low, one line per level |
| flt | input | NFLT | Fault flags, active high: card supply overcurrent, programming supply overcurrent, card removed, overtemperature, main supply dropout, logic supply dropout |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | I/O buffer enable, low = high impedance |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset level, high = released |
| vpp_en | output | 1 | Programming supply enable |
| vpp_lvl | output | 2 | Programming level code, 0 when off |
| irq_n | output | 1 | Fault interrupt, active low, latched |

## Verification
Every output is a register, so each result appears exactly a whole number of edges after its stimulus. A request, a selection, a withdrawal or a fault flag takes effect at the first edge that sees it. Every later step follows after STEP_CYC more edges, idle comes one edge after the last step, and the interrupt release comes one edge after idle. The bench drives inputs on the falling edge and, when it drives each stimulus, enqueues the expected output word for the exact cycle it is due. A falling-edge monitor pops each entry in its cycle and compares it. It also probes the cycle just before each step is due, so an early step is caught as well as a late one.

// File: rtl/sc_session_seq.sv
module sc_session_seq #(
  parameter int STEP_CYC = 8,
  parameter int NFLT     = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sess_req_n,
  input  logic [2:0]      psel_n,
  input  logic [NFLT-1:0] flt,
  output logic            vcc_en,
  output logic            io_en,
  output logic            clk_en,
  output logic            card_rst,
  output logic            vpp_en,
  output logic [1:0]      vpp_lvl,
  output logic            irq_n
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_RUN, S_DEACT} st_t;

  st_t           st;
  logic [2:0]    lvl;
  logic [CW-1:0] cnt;
  logic          flat;
  logic          wr;
  logic [1:0]    code;

  wire       any_flt = |flt;
  wire       stop    = any_flt | sess_req_n;
  wire       tick    = (cnt == CW'(STEP_CYC - 1));
  wire [2:0] want    = ~psel_n;
  wire       one     = $onehot(want);
  wire [1:0] selcode = want[0] ? 2'd1 : (want[1] ? 2'd2 : 2'd3);

  function automatic logic [2:0] step_down(input logic [2:0] l);
    if (l >= 3'd3)      return 3'd2;
    else if (l == 3'd0) return 3'd0;
    else                return l - 3'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      lvl  <= 3'd0;
      cnt  <= '0;
      flat <= 1'b0;
      wr   <= 1'b0;
      code <= 2'd0;
    end else begin
      if (any_flt)                        flat <= 1'b1;
      else if (st == S_IDLE && sess_req_n) flat <= 1'b0;

      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!sess_req_n && !any_flt && !flat) begin
            st  <= S_ACT;
            lvl <= 3'd1;
          end
        end
        S_ACT: begin
          if (stop) begin
            st  <= S_DEACT;
            lvl <= step_down(lvl);
            cnt <= '0;
          end else if (tick) begin
            cnt <= '0;
            lvl <= lvl + 3'd1;
            if (lvl == 3'd3) st <= S_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RUN: begin
          if (stop) begin
            st  <= S_DEACT;
            lvl <= 3'd2;
            cnt <= '0;
          end else if (!wr && one) begin
            wr   <= 1'b1;
            code <= selcode;
          end else if (wr && psel_n == 3'b111) begin
            wr <= 1'b0;
          end
        end
        S_DEACT: begin
          if (lvl == 3'd0) begin
            st <= S_IDLE;
          end else if (tick) begin
            cnt <= '0;
            lvl <= step_down(lvl);
            if (lvl == 3'd2) wr <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign vcc_en   = (lvl >= 3'd1);
  assign io_en    = (lvl >= 3'd2);
  assign clk_en   = (lvl >= 3'd3);
  assign card_rst = (lvl >= 3'd4);
  assign vpp_en   = wr;
  assign vpp_lvl  = wr ? code : 2'd0;
  assign irq_n    = ~flat;

  a_r4_vpp_needs_io: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_en |-> io_en && vpp_lvl != 2'd0);

  a_r6_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_en && $past(vpp_en)) |-> $stable(vpp_lvl));

  a_r9_fault_irq: assert property (@(posedge clk) disable iff (!rst_n)
    any_flt |=> !irq_n);

  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> !vcc_en && $past(sess_req_n));

  a_r12_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> $past(irq_n) && $past(flt) == '0);
endmodule

// File: tb/sc_session_seq_test.sv
module sc_session_seq_test;
  localparam int PER = 10;
  localparam int S   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sess_req_n = 1'b1;
  logic [2:0] psel_n = 3'b111;
  logic [5:0] flt = '0;
  logic       vcc_en, io_en, clk_en, card_rst, vpp_en, irq_n;
  logic [1:0] vpp_lvl;

  sc_session_seq #(.STEP_CYC(S), .NFLT(6)) uut (
    .clk(clk), .rst_n(rst_n), .sess_req_n(sess_req_n), .psel_n(psel_n), .flt(flt),
    .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst),
    .vpp_en(vpp_en), .vpp_lvl(vpp_lvl), .irq_n(irq_n));

  always #(PER/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; logic [7:0] v; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  wire [7:0] o = {irq_n, vpp_en, vpp_lvl, card_rst, clk_en, io_en, vcc_en};

  localparam logic [7:0] OFF = 8'h80, L1 = 8'h81, L2 = 8'h83, L3 = 8'h87, L4 = 8'h8F;

  task automatic want(int at, logic [7:0] v, string tag);
    exp_t e;
    e.at = at; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push_act(int e0);
    want(e0, L1, "R2");
    want(e0 + S - 1, L1, "R2");
    want(e0 + S, L2, "R2");
    want(e0 + 2*S - 1, L2, "R2");
    want(e0 + 2*S, L3, "R2");
    want(e0 + 3*S, L4, "R2");
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (e.at != cyc || o !== e.v) begin
        bad++;
        $display("FAIL %s cycle %0d: actual=%b expected=%b", e.tag, e.at, o, e.v);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PER * 20000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int c, t, f, g, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    want(cyc + 1, OFF, "R1");
    want(cyc + 2, OFF, "R1");
    wait_to(cyc + 3);

    // R2 R3 normal activation
    c = cyc; sess_req_n = 1'b0;
    push_act(c + 1);
    want(c + 1 + 3*S + 5, L4, "R3");
    wait_to(c + 1 + 3*S + 6);

    // R4 R5 R6 programming supply
    c = cyc; psel_n = 3'b101;
    want(c + 1, 8'hEF, "R4");
    wait_to(c + 3); psel_n = 3'b110;
    want(c + 4, 8'hEF, "R6"); want(c + 5, 8'hEF, "R6");
    wait_to(c + 6); psel_n = 3'b111;
    want(c + 7, L4, "R6");
    wait_to(c + 9); psel_n = 3'b100;
    want(c + 10, L4, "R5"); want(c + 12, L4, "R5");
    wait_to(c + 13); psel_n = 3'b111;
    wait_to(c + 14); psel_n = 3'b110;
    want(c + 15, 8'hDF, "R4");
    wait_to(c + 17); psel_n = 3'b111;
    want(c + 18, L4, "R6");
    wait_to(c + 19); psel_n = 3'b011;
    want(c + 20, 8'hFF, "R4");
    wait_to(c + 22);

    // R7 R8 withdrawal with programming supply on, then restart
    t = cyc; sess_req_n = 1'b1; psel_n = 3'b111;
    want(t + 1, 8'hF3, "R7"); want(t + S, 8'hF3, "R7");
    want(t + 1 + S, L1, "R7"); want(t + 2*S, L1, "R7");
    want(t + 1 + 2*S, OFF, "R7");
    wait_to(t + 1 + 2*S); sess_req_n = 1'b0;
    want(t + 2 + 2*S, OFF, "R8");
    push_act(t + 3 + 2*S);
    wait_to(t + 3 + 5*S + 2);

    // R9 R11 R12 fault while running, host keeps request low
    f = cyc; flt[3] = 1'b1;
    want(f + 1, 8'h03, "R9");
    wait_to(f + 1); flt = '0;
    want(f + 1 + S, 8'h01, "R9"); want(f + 1 + 2*S, 8'h00, "R9");
    want(f + 5 + 2*S, 8'h00, "R11"); want(f + 6 + 2*S, 8'h00, "R12");
    wait_to(f + 6 + 2*S);
    g = cyc; sess_req_n = 1'b1;
    want(g + 1, OFF, "R11");
    wait_to(g + 3);

    // R12 fault in idle blocks a request
    c = cyc; sess_req_n = 1'b0; flt[0] = 1'b1;
    want(c + 1, 8'h00, "R12");
    wait_to(c + 1); flt = '0;
    want(c + 4, 8'h00, "R12");
    wait_to(c + 4); sess_req_n = 1'b1;
    want(c + 5, OFF, "R11");
    wait_to(c + 6);

    // R10 fault during activation at step two
    c = cyc; sess_req_n = 1'b0;
    want(c + 1, L1, "R2");
    wait_to(c + S + 2); flt[1] = 1'b1;
    want(c + S + 3, 8'h01, "R10");
    wait_to(c + S + 3); flt = '0;
    want(c + 2*S + 2, 8'h01, "R10"); want(c + 2*S + 3, 8'h00, "R10");
    wait_to(c + 2*S + 3); sess_req_n = 1'b1;
    want(c + 2*S + 4, 8'h00, "R11"); want(c + 2*S + 5, OFF, "R11");
    wait_to(c + 2*S + 7);

    // R10 fault during activation at step three
    c = cyc; sess_req_n = 1'b0;
    wait_to(c + 2*S + 1); flt[2] = 1'b1;
    want(c + 2*S + 2, 8'h03, "R10");
    wait_to(c + 2*S + 2); flt = '0; sess_req_n = 1'b1;
    want(c + 3*S + 2, 8'h01, "R10"); want(c + 4*S + 2, 8'h00, "R10");
    want(c + 4*S + 3, 8'h00, "R11"); want(c + 4*S + 4, OFF, "R11");
    wait_to(c + 4*S + 6);

    // R9 R11 fault during a host withdrawal
    c = cyc; sess_req_n = 1'b0;
    push_act(c + 1);
    wait_to(c + 3*S + 2);
    t = cyc; sess_req_n = 1'b1;
    want(t + 1, L2, "R7");
    wait_to(t + 2); flt[4] = 1'b1;
    want(t + 3, 8'h03, "R9");
    wait_to(t + 3); flt = '0;
    want(t + 1 + S, 8'h01, "R11"); want(t + 1 + 2*S, 8'h00, "R11");
    want(t + 2 + 2*S, 8'h00, "R11"); want(t + 3 + 2*S, OFF, "R11");
    wait_to(t + 5 + 2*S);

    // R9 each fault bit alone in idle
    for (int i = 0; i < 6; i++) begin
      n = cyc; flt[i] = 1'b1;
      want(n + 1, 8'h00, "R9");
      wait_to(n + 1); flt = '0;
      want(n + 2, OFF, "R11");
      wait_to(n + 3);
    end

    wait_to(cyc + 2);
    if (q.size() > 0) begin
      bad++;
      $display("FAIL queue: actual=%0d pending expected=0", q.size());
    end
    finish_run();
  end
endmodule